// File: doc/BRIEF.md
# Cascaded Three-Bank Interrupt Controller

This block gathers up to 96 interrupt requests in three 32-bit banks. Two of the banks are main banks, low and high. They take level requests from on-chip units, and each input is registered for one cycle. The third bank is a port bank. It catches rising edges on 32 general-purpose pins and holds them in a sticky cause register. Four bits of the high bank do not come from inputs. Each of them is the OR of eight masked port-bank causes, so the port bank sits in a cascade below the high bank.

Every bank has a mask. Arbitration walks the low bank first and the high bank second. When the high-bank winner is a port summary bit, arbitration descends into the port bank. The result is a flat vector number from 0 to 95 with a valid flag, and the CPU interrupt line follows that flag. Software reads causes and reads or writes masks through a simple register port. It also has two ways to retire a port interrupt: it can write the port cause register, or it can pulse an acknowledge input.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: The vector number is the bit index for low bank bit i (0..31). High bank bit j below 24 gives vector 32+j. Port bank bit k gives vector 64+k.
- R2: Only low bits set in 0x3DFFFFFE and high bits set in 0x0F000DB7 take part in arbitration. A pending unimplemented bit alone leaves vec_valid low.
- R3: Each bank's cause is ANDed with its mask before arbitration. A mask written at one clock edge is in force for the selection seen after that edge.
- R4: Any pending masked low bit beats every high bit. Within a bank, the lowest pending index wins.
- R5: High bits 24..27 are the ORs of masked port cause bits 0-7, 8-15, 16-23 and 24-31, and they are visible in the high cause register. When one of them wins, the vector is 64 plus the lowest set bit of the masked port cause.
- R6: With nothing eligible, vec_valid=0, vec_num=127 and cpu_irq=0. Otherwise cpu_irq=1.
- R7: A port cause bit sets on a rising edge of its pin and stays set after the pin falls. A rising edge in the same cycle as a clearing write leaves the bit set.
- R8: A write to the port cause register (address 2) clears the bits written 0 and leaves the bits written 1 unchanged.
- R9: ack_i clears only the port cause bit of the currently selected vector, and only when that vector is in 64..95. Otherwise ack_i changes nothing.
- R10: After reset, the low mask and port mask are 0, the high mask is 0x0F000000, and the port cause is 0.
- R11: The register map is: address 0 low cause (read only), 1 high cause (read only), 2 port cause, 3 low mask, 4 high mask, 5 port mask. Reads are combinational.
- R12: Main bank causes follow their level inputs with one cycle of delay. Input bits 24..27 of the high bank are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_src | input | 32 | Low main bank level requests |
| high_src | input | 32 | High main bank level requests (bits 24..27 unused) |
| port_in | input | 32 | Port pins, rising-edge sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ack_i | input | 1 | Acknowledge the selected port vector |
| vec_valid | output | 1 | A vector is selected |
| vec_num | output | 7 | Selected vector, 127 when none |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The hardest case to reach is a rising port edge that lands in the same cycle as a write to the port cause register that would clear that bit. To get there, the stimulus first latches the bit. It then drops the pin for one cycle so that a new edge is possible. Finally, at a single falling clock edge it raises the pin and issues the clearing write together. Acknowledge is also tried while a low-bank vector holds the selection, and the bench confirms that the sticky port cause keeps its value.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LOW_CAUSE  = 3'd0,
        RA_HIGH_CAUSE = 3'd1,
        RA_PORT_CAUSE = 3'd2,
        RA_LOW_MASK   = 3'd3,
        RA_HIGH_MASK  = 3'd4,
        RA_PORT_MASK  = 3'd5
    } cic_addr_e;

endpackage

// File: rtl/cic_lsb_enc.sv
// Finds the lowest set bit of a request vector.
module cic_lsb_enc #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/cic_port_bank.sv
// Edge-captured sticky cause bank with mask and write-zero-to-clear.
module cic_port_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic         wr_cause,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] cause,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] cause;
        logic [W-1:0] mask;
    } pb_state_t;

    pb_state_t st_d, st_q;
    logic [W-1:0] rise;
    logic [W-1:0] keep;

    always_comb begin
        st_d      = st_q;
        rise      = pin & ~st_q.prev;
        keep      = wr_cause ? wdata : '1;
        st_d.prev = pin;
        // new edges win over any clear in the same cycle
        st_d.cause = (st_q.cause & keep & ~ack_clr) | rise;
        if (wr_mask) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause  = st_q.cause;
    assign mask   = st_q.mask;
    assign masked = st_q.cause & st_q.mask;

endmodule

// File: rtl/cic_resolver.sv
// Low bank first, then high bank, descending into the port bank on a summary win.
module cic_resolver #(
    parameter int BANK_W   = 32,
    parameter int SUM_BASE = 24,
    localparam int IW      = $clog2(BANK_W),
    localparam int VEC_W   = $clog2(3 * BANK_W + 1)
) (
    input  logic [BANK_W-1:0] low_elig,
    input  logic [BANK_W-1:0] high_elig,
    input  logic [BANK_W-1:0] port_elig,
    output logic              sel_valid,
    output logic [VEC_W-1:0]  sel_num,
    output logic              port_hit,
    output logic [IW-1:0]     port_idx
);

    logic          low_found, high_found, port_found;
    logic [IW-1:0] low_idx, high_idx;

    cic_lsb_enc #(.W(BANK_W)) u_enc_low (
        .req(low_elig), .found(low_found), .idx(low_idx)
    );
    cic_lsb_enc #(.W(BANK_W)) u_enc_high (
        .req(high_elig), .found(high_found), .idx(high_idx)
    );
    cic_lsb_enc #(.W(BANK_W)) u_enc_port (
        .req(port_elig), .found(port_found), .idx(port_idx)
    );

    always_comb begin
        sel_valid = 1'b0;
        sel_num   = '1;
        port_hit  = 1'b0;
        if (low_found) begin
            sel_valid = 1'b1;
            sel_num   = VEC_W'(low_idx);
        end else if (high_found) begin
            if (int'(high_idx) >= SUM_BASE) begin
                if (port_found) begin
                    sel_valid = 1'b1;
                    port_hit  = 1'b1;
                    sel_num   = VEC_W'(2 * BANK_W) + VEC_W'(port_idx);
                end
            end else begin
                sel_valid = 1'b1;
                sel_num   = VEC_W'(BANK_W) + VEC_W'(high_idx);
            end
        end
    end

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
    parameter int               BANK_W        = 32,
    parameter logic [31:0]      LOW_IMPL      = 32'h3DFF_FFFE,
    parameter logic [31:0]      HIGH_IMPL     = 32'h0F00_0DB7,
    parameter logic [31:0]      HIGH_MASK_RST = 32'h0F00_0000,
    parameter int               SUM_BASE      = 24,
    parameter int               SUM_CNT       = 4,
    localparam int              VEC_W         = $clog2(3 * BANK_W + 1),
    localparam int              IW            = $clog2(BANK_W),
    localparam int              GRP_W         = BANK_W / SUM_CNT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BANK_W-1:0]            low_src,
    input  logic [BANK_W-1:0]            high_src,
    input  logic [BANK_W-1:0]            port_in,
    input  logic                         reg_we,
    input  logic [cic_pkg::ADDR_W-1:0]   reg_addr,
    input  logic [BANK_W-1:0]            reg_wdata,
    output logic [BANK_W-1:0]            reg_rdata,
    input  logic                         ack_i,
    output logic                         vec_valid,
    output logic [VEC_W-1:0]             vec_num,
    output logic                         cpu_irq
);
    import cic_pkg::*;

    typedef struct packed {
        logic [BANK_W-1:0] low_cause;
        logic [BANK_W-1:0] high_raw;
        logic [BANK_W-1:0] low_mask;
        logic [BANK_W-1:0] high_mask;
    } main_state_t;

    main_state_t st_d, st_q;

    logic [BANK_W-1:0] port_cause, port_mask, port_masked;
    logic [BANK_W-1:0] high_cause;
    logic [SUM_CNT-1:0] summary;
    logic [BANK_W-1:0] low_elig, high_elig;
    logic [BANK_W-1:0] ack_clr;
    logic              wr_pc, wr_pm;
    logic              sel_valid, port_hit;
    logic [VEC_W-1:0]  sel_num;
    logic [IW-1:0]     port_idx;

    // main bank registers
    always_comb begin
        st_d           = st_q;
        st_d.low_cause = low_src;
        st_d.high_raw  = high_src;
        if (reg_we && reg_addr == RA_LOW_MASK) begin
            st_d.low_mask = reg_wdata;
        end
        if (reg_we && reg_addr == RA_HIGH_MASK) begin
            st_d.high_mask = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.high_mask <= HIGH_MASK_RST[BANK_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    // port bank summaries replace the high-bank input bits
    for (genvar g = 0; g < SUM_CNT; g++) begin : g_sum
        assign summary[g] = |port_masked[g*GRP_W +: GRP_W];
    end

    always_comb begin
        high_cause = st_q.high_raw;
        high_cause[SUM_BASE +: SUM_CNT] = summary;
    end

    assign low_elig  = st_q.low_cause & st_q.low_mask & LOW_IMPL[BANK_W-1:0];
    assign high_elig = high_cause & st_q.high_mask & HIGH_IMPL[BANK_W-1:0];

    assign wr_pc = reg_we && (reg_addr == RA_PORT_CAUSE);
    assign wr_pm = reg_we && (reg_addr == RA_PORT_MASK);

    always_comb begin
        ack_clr = '0;
        if (ack_i && port_hit) begin
            ack_clr[port_idx] = 1'b1;
        end
    end

    cic_port_bank #(.W(BANK_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (port_in),
        .wr_cause (wr_pc),
        .wr_mask  (wr_pm),
        .wdata    (reg_wdata),
        .ack_clr  (ack_clr),
        .cause    (port_cause),
        .mask     (port_mask),
        .masked   (port_masked)
    );

    cic_resolver #(.BANK_W(BANK_W), .SUM_BASE(SUM_BASE)) u_res (
        .low_elig  (low_elig),
        .high_elig (high_elig),
        .port_elig (port_masked),
        .sel_valid (sel_valid),
        .sel_num   (sel_num),
        .port_hit  (port_hit),
        .port_idx  (port_idx)
    );

    always_comb begin
        case (reg_addr)
            RA_LOW_CAUSE:  reg_rdata = st_q.low_cause;
            RA_HIGH_CAUSE: reg_rdata = high_cause;
            RA_PORT_CAUSE: reg_rdata = port_cause;
            RA_LOW_MASK:   reg_rdata = st_q.low_mask;
            RA_HIGH_MASK:  reg_rdata = st_q.high_mask;
            RA_PORT_MASK:  reg_rdata = port_mask;
            default:       reg_rdata = '0;
        endcase
    end

    assign vec_valid = sel_valid;
    assign vec_num   = sel_num;
    assign cpu_irq   = sel_valid;

endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
    parameter int          BANK_W    = 32,
    parameter logic [31:0] LOW_IMPL  = 32'h3DFF_FFFE,
    parameter logic [31:0] HIGH_IMPL = 32'h0F00_0DB7,
    parameter int          SUM_BASE  = 24,
    localparam int         VEC_W     = $clog2(3 * BANK_W + 1),
    localparam int         IW        = $clog2(BANK_W)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 vec_valid,
    input logic [VEC_W-1:0]     vec_num,
    input logic                 cpu_irq,
    input logic                 reg_we,
    input logic [2:0]           reg_addr,
    input logic [BANK_W-1:0]    reg_wdata,
    input logic                 ack_i,
    input logic [BANK_W-1:0]    port_cause,
    input logic [BANK_W-1:0]    port_mask
);

    logic [IW-1:0] sub_idx;
    logic          in_low, in_high, in_port;

    assign sub_idx = vec_num[IW-1:0];
    assign in_low  = vec_valid && (int'(vec_num) < BANK_W);
    assign in_high = vec_valid && (int'(vec_num) >= BANK_W) && (int'(vec_num) < 2 * BANK_W);
    assign in_port = vec_valid && (int'(vec_num) >= 2 * BANK_W) && (int'(vec_num) < 3 * BANK_W);

    a_r2_low_impl: assert property (@(posedge clk) disable iff (!rst_n)
        in_low |-> LOW_IMPL[sub_idx]);

    a_r2_high_impl: assert property (@(posedge clk) disable iff (!rst_n)
        in_high |-> (HIGH_IMPL[sub_idx] && int'(sub_idx) < SUM_BASE));

    a_r5_port_masked: assert property (@(posedge clk) disable iff (!rst_n)
        in_port |-> (port_mask[sub_idx] && port_cause[sub_idx]));

    a_r6_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_num == '1 && !cpu_irq));

    a_r3_low_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3 && reg_wdata == '0) |=> !in_low);

    a_r8_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd2 && reg_wdata == '1 && !ack_i)
        |=> (($past(port_cause) & ~port_cause) == '0));

endmodule

bind cascade_irq_ctrl cic_checker #(
    .BANK_W    (BANK_W),
    .LOW_IMPL  (LOW_IMPL),
    .HIGH_IMPL (HIGH_IMPL),
    .SUM_BASE  (SUM_BASE)
) u_cic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_valid  (vec_valid),
    .vec_num    (vec_num),
    .cpu_irq    (cpu_irq),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ack_i      (ack_i),
    .port_cause (port_cause),
    .port_mask  (port_mask)
);

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] low_src = '0;
    logic [31:0] high_src = '0;
    logic [31:0] port_in = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ack_i = 1'b0;
    logic        vec_valid;
    logic [6:0]  vec_num;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cascade_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .low_src(low_src), .high_src(high_src),
        .port_in(port_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_i(ack_i),
        .vec_valid(vec_valid), .vec_num(vec_num), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_vec(input string tag, input logic v, input logic [6:0] n);
        check({tag, " valid"}, {31'd0, vec_valid}, {31'd0, v});
        check({tag, " num"}, {25'd0, vec_num}, {25'd0, n});
        check({tag, " irq"}, {31'd0, cpu_irq}, {31'd0, v});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(3'd3, d); check("R10 low mask", d, 32'h0);
        reg_read(3'd4, d); check("R10 high mask", d, 32'h0F00_0000);
        reg_read(3'd5, d); check("R10 port mask", d, 32'h0);
        reg_read(3'd2, d); check("R10 port cause", d, 32'h0);
        check_vec("R6 idle", 1'b0, 7'h7F);
    endtask

    task automatic t_low();
        logic [31:0] d;
        reg_write(3'd3, 32'hFFFF_FFFF);
        low_src = (32'h1 << 9) | (32'h1 << 5);
        step();
        check_vec("R4 R1 low lowest", 1'b1, 7'd5);
        reg_read(3'd0, d); check("R12 R11 low cause", d, 32'h0000_0220);
        low_src = 32'h1 | (32'h1 << 25);
        step();
        check_vec("R2 low unimpl", 1'b0, 7'h7F);
        low_src = 32'h1 << 24;
        step();
        check_vec("R2 R1 low bit24", 1'b1, 7'd24);
    endtask

    task automatic t_mask_timing();
        reg_write(3'd3, 32'h0);
        low_src = 32'h1 << 5;
        step();
        check_vec("R3 masked off", 1'b0, 7'h7F);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h20;
        #1;
        check_vec("R3 before edge", 1'b0, 7'h7F);
        step();
        reg_we = 1'b0;
        check_vec("R3 after edge", 1'b1, 7'd5);
        reg_write(3'd3, 32'hFFFF_FFFF);
        low_src = '0;
    endtask

    task automatic t_high();
        reg_write(3'd4, 32'h0F00_0DB7);
        high_src = (32'h1 << 7) | (32'h1 << 2);
        step();
        check_vec("R1 R4 high", 1'b1, 7'd34);
        low_src = 32'h1 << 9;
        step();
        check_vec("R4 low over high", 1'b1, 7'd9);
        low_src = '0;
        high_src = (32'h1 << 3) | (32'hF << 24);
        step();
        check_vec("R2 R12 high unimpl", 1'b0, 7'h7F);
        high_src = '0;
        step();
    endtask

    task automatic t_port();
        logic [31:0] d;
        reg_write(3'd5, 32'hFFFF_FFFF);
        port_in = 32'h1 << 12;
        step();
        check_vec("R5 R7 port 12", 1'b1, 7'd76);
        reg_read(3'd1, d); check("R5 summary bit25", d, 32'h0200_0000);
        port_in = (32'h1 << 12) | (32'h1 << 3);
        step();
        check_vec("R5 port lowest", 1'b1, 7'd67);
        port_in = '0;
        step();
        reg_read(3'd2, d); check("R7 sticky", d, 32'h0000_1008);
        reg_write(3'd2, 32'hFFFF_FFF7);
        reg_read(3'd2, d); check("R8 w0c", d, 32'h0000_1000);
        check_vec("R8 vec after clear", 1'b1, 7'd76);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        ack_i = 1'b1; step(); ack_i = 1'b0;
        reg_read(3'd2, d); check("R9 ack clears", d, 32'h0);
        check_vec("R9 after ack", 1'b0, 7'h7F);
        port_in = 32'h0000_1008;
        step();
        low_src = 32'h1 << 9;
        step();
        ack_i = 1'b1; step(); ack_i = 1'b0;
        reg_read(3'd2, d); check("R9 ack low no effect", d, 32'h0000_1008);
        low_src = '0;
        step();
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        port_in = 32'h0000_1000;
        step();
        port_in = 32'h0000_1008;
        reg_write(3'd2, 32'hFFFF_FFF7);
        reg_read(3'd2, d); check("R7 set beats clear", d, 32'h0000_1008);
        reg_write(3'd5, 32'h0);
        check_vec("R3 port mask off", 1'b0, 7'h7F);
        reg_read(3'd1, d); check("R5 summary gone", d, 32'h0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_low();
        t_mask_timing();
        t_high();
        t_port();
        t_ack();
        t_set_wins();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule